// File: doc/BRIEF.md
# Video Region Color Averager

This block watches a decoded video stream of 24-bit RGB pixels that arrives with horizontal and vertical sync, all on the pixel clock. It works out each pixel's screen position from the sync signals and adds each color channel into an accumulator for the screen rectangle (one per LED) that the pixel falls in. No frame is stored. Every rectangle covers the same power-of-two number of pixels, so the average is taken from the upper bits of the accumulator and no divider is needed.

The accumulators come in two banks. One bank collects the frame being received. The other holds the last finished frame and can be read. On each vertical sync edge the banks swap roles, the bank that now collects is cleared, and a one-cycle `frame_done` pulse tells a downstream LED driver that fresh averages are ready. The driver reads them through a small index/data port with one cycle of latency.

The pixel input is a valid/ready stream. The block never applies back-pressure: `in_ready` rises after reset and stays high, and every cycle with `in_valid` high is consumed. A source may leave `in_valid` low between pixels at any time. Holding data while `in_ready` is low is needed only during reset.

Rectangles are laid out by parameters. Region `r` spans columns `X0 + r*PITCH` up to `X0 + r*PITCH + 2^LOG_W - 1` and rows `Y0` up to `Y0 + 2^LOG_H - 1`.

Top module: `region_averager`

## Requirements
- R1: `in_ready` is low during reset and high on every cycle after it, so every cycle with `in_valid` high transfers a pixel.
- R2: The column count starts at 0 and advances by one for each transferred pixel taken outside sync. It returns to 0 on a rising edge of `in_hsync`. The row count advances by one on each rising edge of `in_hsync`. Both counts return to 0 on a rising edge of `in_vsync`. Cycles with `in_valid` low move neither count.
- R3: A sync pulse of any length counts as a single edge. Pixels transferred while either sync is high are discarded and do not move the column count.
- R4: A pixel at column x and row y adds to region r only when `X0+r*PITCH <= x < X0+r*PITCH+2^LOG_W` and `Y0 <= y < Y0+2^LOG_H`. Pixels outside every region change no result.
- R5: Each published channel equals the floor of the channel sum over the region divided by 2^(LOG_W+LOG_H). A region filled with 255 publishes 255, with no overflow.
- R6: `frame_done` is high for exactly one cycle: the cycle after the clock edge at which a rising edge of `in_vsync` is first seen. That edge also swaps the banks.
- R7: `rd_data` shows, one cycle after `rd_idx` is presented, the averages of region `rd_idx` from the published bank, packed as red in bits 23:16, green in 15:8 and blue in 7:0. The same packing is used for `in_rgb`.
- R8: Published averages stay constant while the next frame accumulates. Before the first vertical sync edge every region reads 0.
- R9: At each swap the bank that starts collecting is cleared, so a frame's averages never include sums from earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel stream valid |
| in_ready | output | 1 | Pixel stream ready (high whenever out of reset) |
| in_rgb | input | 24 | Pixel color, red 23:16, green 15:8, blue 7:0 |
| in_hsync | input | 1 | Horizontal sync, active high, ends a line |
| in_vsync | input | 1 | Vertical sync, active high, ends a frame |
| rd_idx | input | IDXW | Region index to read |
| rd_data | output | 24 | Averaged RGB of the selected region, registered |
| frame_done | output | 1 | One-cycle pulse when a new frame is published |

## Verification
The averaging is tried with four frames. A position-dependent color ramp gives every region a different sum, so any shift in column or row counting shows up as a wrong average. An all-white frame probes the accumulator width at full scale. A frame that is black inside the regions and white everywhere else, sent right after the white one, separates a correct region decode and bank clear from leakage or stale sums. The last frame has idle gaps between pixels and long sync pulses, which exposes a count that moves on idle cycles or on every cycle of a held sync. Published values are read back twice during the following frame to show they hold steady.

// File: rtl/region_avg_pkg.sv
package region_avg_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam int NUM_CH = 3;
endpackage

// File: rtl/sync_pos_tracker.sv
module sync_pos_tracker #(
  parameter int XW = 12,
  parameter int YW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_xfer,
  input  logic          hsync,
  input  logic          vsync,
  output logic [XW-1:0] pos_x,
  output logic [YW-1:0] pos_y,
  output logic          pix_take,
  output logic          frame_swap
);
  logic hs_q, vs_q;
  logic hs_rise, vs_rise;

  assign hs_rise    = hsync & ~hs_q;
  assign vs_rise    = vsync & ~vs_q;
  assign pix_take   = pix_xfer & ~hsync & ~vsync;
  assign frame_swap = vs_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      pos_x <= '0;
      pos_y <= '0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (vs_rise) begin
        pos_x <= '0;
        pos_y <= '0;
      end else if (hs_rise) begin
        pos_x <= '0;
        if (pos_y != '1) pos_y <= pos_y + 1'b1;
      end else if (pix_take && pos_x != '1) begin
        pos_x <= pos_x + 1'b1;
      end
    end
  end

  // R2
  x_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> (pos_x == '0));
  // R2
  y_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (pos_y == '0));
  // R3
  held_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && hs_q && !vs_rise) |=> $stable(pos_y));
endmodule

// File: rtl/region_match.sv
module region_match #(
  parameter int NREG  = 4,
  parameter int XW    = 12,
  parameter int YW    = 11,
  parameter int X0    = 2,
  parameter int Y0    = 1,
  parameter int PITCH = 6,
  parameter int LOG_W = 2,
  parameter int LOG_H = 1
) (
  input  logic [XW-1:0]   pos_x,
  input  logic [YW-1:0]   pos_y,
  input  logic            pix_take,
  output logic [NREG-1:0] hit
);
  localparam int RW = 1 << LOG_W;
  localparam int RH = 1 << LOG_H;

  logic row_in;
  assign row_in = (int'(pos_y) >= Y0) && (int'(pos_y) < Y0 + RH);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam int LO = X0 + r * PITCH;
    assign hit[r] = pix_take && row_in &&
                    (int'(pos_x) >= LO) && (int'(pos_x) < LO + RW);
  end
endmodule

// File: rtl/region_bank.sv
module region_bank
  import region_avg_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int LOG_A = 3,
  parameter int IDXW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] hit,
  input  rgb_t            pix,
  input  logic            swap,
  input  logic [IDXW-1:0] rd_idx,
  output rgb_t            rd_data,
  output logic            frame_done
);
  localparam int AW = 8 + LOG_A;

  logic [AW-1:0] acc [2][NREG][NUM_CH];
  logic          wr_bank;
  logic [7:0]    chan [NUM_CH];
  logic [AW-1:0] pub0;

  assign chan[0] = pix.r;
  assign chan[1] = pix.g;
  assign chan[2] = pix.b;
  assign pub0    = acc[~wr_bank][0][0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank    <= 1'b0;
      frame_done <= 1'b0;
      rd_data    <= '0;
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < NREG; r++)
          for (int c = 0; c < NUM_CH; c++)
            acc[b][r][c] <= '0;
    end else begin
      frame_done <= swap;
      if (swap) begin
        wr_bank <= ~wr_bank;
        for (int r = 0; r < NREG; r++)
          for (int c = 0; c < NUM_CH; c++)
            acc[~wr_bank][r][c] <= '0;
      end else begin
        for (int r = 0; r < NREG; r++)
          if (hit[r])
            for (int c = 0; c < NUM_CH; c++)
              acc[wr_bank][r][c] <= acc[wr_bank][r][c] + {{LOG_A{1'b0}}, chan[c]};
      end
      if (int'(rd_idx) < NREG) begin
        rd_data.r <= acc[~wr_bank][rd_idx][0][AW-1:LOG_A];
        rd_data.g <= acc[~wr_bank][rd_idx][1][AW-1:LOG_A];
        rd_data.b <= acc[~wr_bank][rd_idx][2][AW-1:LOG_A];
      end else begin
        rd_data <= '0;
      end
    end
  end

  // R6
  done_after_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> frame_done);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R9
  bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (acc[wr_bank][0][0] == '0));
  // R8
  pub_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(pub0));
endmodule

// File: rtl/region_averager.sv
module region_averager
  import region_avg_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int XW    = 12,
  parameter int YW    = 11,
  parameter int X0    = 2,
  parameter int Y0    = 1,
  parameter int PITCH = 6,
  parameter int LOG_W = 2,
  parameter int LOG_H = 1,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [23:0]     in_rgb,
  input  logic            in_hsync,
  input  logic            in_vsync,
  input  logic [IDXW-1:0] rd_idx,
  output logic [23:0]     rd_data,
  output logic            frame_done
);
  localparam int LOG_A = LOG_W + LOG_H;

  logic [XW-1:0]   pos_x;
  logic [YW-1:0]   pos_y;
  logic            pix_take, frame_swap;
  logic [NREG-1:0] hit;
  rgb_t            rd_pix;

  always_ff @(posedge clk) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  sync_pos_tracker #(.XW(XW), .YW(YW)) u_pos (
    .clk(clk), .rst_n(rst_n), .pix_xfer(in_valid & in_ready),
    .hsync(in_hsync), .vsync(in_vsync), .pos_x(pos_x), .pos_y(pos_y),
    .pix_take(pix_take), .frame_swap(frame_swap)
  );

  region_match #(.NREG(NREG), .XW(XW), .YW(YW), .X0(X0), .Y0(Y0),
                 .PITCH(PITCH), .LOG_W(LOG_W), .LOG_H(LOG_H)) u_match (
    .pos_x(pos_x), .pos_y(pos_y), .pix_take(pix_take), .hit(hit)
  );

  region_bank #(.NREG(NREG), .LOG_A(LOG_A), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst_n(rst_n), .hit(hit), .pix(rgb_t'(in_rgb)),
    .swap(frame_swap), .rd_idx(rd_idx), .rd_data(rd_pix),
    .frame_done(frame_done)
  );

  assign rd_data = rd_pix;

  // R4
  one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  // R1
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> in_ready);
endmodule

// File: tb/region_averager_tb.sv
module region_averager_tb;
  localparam int LINEW = 28;
  localparam int LINES = 5;
  localparam int NREG  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_rgb = '0;
  logic        in_hsync = 1'b0;
  logic        in_vsync = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic [23:0] rd_data;
  logic        frame_done;

  int n_chk = 0;
  int n_bad = 0;
  int frames_seen = 0;
  logic [23:0] exp_q [$];

  always #10 clk = ~clk;

  region_averager u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rgb(in_rgb), .in_hsync(in_hsync), .in_vsync(in_vsync),
    .rd_idx(rd_idx), .rd_data(rd_data), .frame_done(frame_done)
  );

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  // region layout of the requirements (R4): columns 2+6r..5+6r, rows 1..2
  function automatic int region_of(int x, int y);
    for (int r = 0; r < NREG; r++)
      if (x >= 2 + 6 * r && x < 6 + 6 * r && y >= 1 && y < 3) return r;
    return -1;
  endfunction

  function automatic logic [23:0] pix_of(int mode, int x, int y);
    case (mode)
      0: return {8'(x * 9 + y * 3), 8'(255 - x * 5), 8'(y * 50 + x)};
      1: return 24'hFFFFFF;
      2: return (region_of(x, y) >= 0) ? 24'h000000 : 24'hFFFFFF;
      default: return {8'(x * x), 8'(x + y * 17), 8'd200};
    endcase
  endfunction

  task automatic send_frame(int mode, bit gaps, int slen);
    int sr [NREG], sg [NREG], sb [NREG];
    for (int r = 0; r < NREG; r++) begin sr[r] = 0; sg[r] = 0; sb[r] = 0; end
    for (int y = 0; y < LINES; y++) begin
      for (int x = 0; x < LINEW; x++) begin
        if (gaps && (x % 5 == 2)) begin
          // idle cycle: must not advance the column (R2)
          @(negedge clk); in_valid = 1'b0; in_rgb = 24'hFFFFFF;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_rgb   = pix_of(mode, x, y);
        if (region_of(x, y) >= 0) begin
          sr[region_of(x, y)] += int'(in_rgb[23:16]);
          sg[region_of(x, y)] += int'(in_rgb[15:8]);
          sb[region_of(x, y)] += int'(in_rgb[7:0]);
        end
      end
      // held hsync with valid white data, to be discarded (R3)
      for (int k = 0; k < slen; k++) begin
        @(negedge clk); in_valid = 1'b1; in_rgb = 24'hFFFFFF; in_hsync = 1'b1;
      end
      @(negedge clk); in_hsync = 1'b0; in_valid = 1'b0;
    end
    for (int r = 0; r < NREG; r++)
      exp_q.push_back({8'(sr[r] >> 3), 8'(sg[r] >> 3), 8'(sb[r] >> 3)});
    for (int k = 0; k < slen; k++) begin
      @(negedge clk); in_valid = 1'b1; in_rgb = 24'hFFFFFF; in_vsync = 1'b1;
    end
    @(negedge clk); in_vsync = 1'b0; in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    logic [23:0] first;
    forever begin
      @(negedge clk);
      if (rst_n && frame_done) begin
        rd_idx = 2'd0;
        for (int r = 0; r < NREG; r++) begin
          @(negedge clk);
          if (r == 0) check("R6 pulse width", {23'd0, frame_done}, 24'd0);
          check("R5 R7 region average", rd_data, exp_q.pop_front());
          if (r == 0) first = rd_data;
          rd_idx = 2'(r + 1);
        end
        check("R1 ready", {23'd0, in_ready}, 24'd1);
        rd_idx = 2'd0;
        repeat (40) @(negedge clk);
        check("R8 stable during next frame", rd_data, first);
        frames_seen++;
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {23'd0, in_ready}, 24'd0);
    check("R6 no pulse in reset", {23'd0, frame_done}, 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {23'd0, in_ready}, 24'd1);
    for (int r = 0; r < NREG; r++) begin
      rd_idx = 2'(r);
      @(negedge clk);
      check("R8 zero before first frame", rd_data, 24'd0);
    end
    rd_idx = 2'd0;
    send_frame(0, 1'b0, 1);   // ramp: R2 R4 R5
    send_frame(1, 1'b0, 3);   // full scale: R5, held sync R3
    send_frame(2, 1'b1, 2);   // outside-only white: R4 R9
    send_frame(3, 1'b1, 4);   // gaps and long syncs: R2 R3
    repeat (200) @(negedge clk);
    check("R6 frames published", 24'(frames_seen), 24'd4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule